// File: doc/BRIEF.md
# Load/Store Endian Normaliser

This block is the data-side helper of a load/store unit. It sits between the unit's register-side operands and its memory port, and it puts data into the right byte order in both directions. It has no state: both paths are pure combinational logic.

On a load, the 64-bit word from memory can be byte-swapped within the access length, and the result can then be sign-extended to the full width. On a store, the operand can be byte-swapped within the same access length before it goes to memory. Three controls steer both paths: a swap flag, a sign-extension flag and the access length in bytes. Address generation and all handshakes are handled elsewhere.

Top module: `endian_normaliser`

## Requirements
- R1: With the swap flag low, the store output equals the store operand on every bit. The load output equals the raw memory word when sign extension is also off.
- R2: With the swap flag high and access length L (1, 2, 4 or 8), byte i of the swapped value is byte L-1-i of the input, for every i below L. Byte k means bits 8k+7 down to 8k.
- R3: With the swap flag high, every byte at position L or above is zero after swapping, on both paths.
- R4: A length of 1 leaves the low byte unchanged. A length of 8 reverses all eight bytes.
- R5: With sign extension on and L equal to 2, bits 63:16 of the load output all copy bit 15.
- R6: With sign extension on and any other length (1, 4 or 8), bits 63:32 of the load output all copy bit 31. Bits 31:0 keep their value.
- R7: On the load path, sign extension acts on the value after swapping. Bit 15 or bit 31 is therefore taken from the swapped word.
- R8: The store path uses the same length rules as the load path, and the sign-extension flag has no effect on it.
- R9: Both outputs follow a change on any input within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ld_raw_i | input | 64 | Word returned by the memory port for a load |
| st_opnd_i | input | 64 | Operand to be written to memory on a store |
| swap_en_i | input | 1 | Byte-swap the data within the access length |
| sext_en_i | input | 1 | Sign-extend the load result |
| acc_len_i | input | 4 | Access length in bytes (1, 2, 4, 8) |
| ld_norm_o | output | 64 | Normalised load data towards the register file |
| st_mem_o | output | 64 | Normalised store data towards the memory port |

## Verification
The bench builds the block with its default width: 64 data bits, which gives eight byte lanes, a 4-bit length field, and sign-extension points at 16 and 32 bits. At this width the full swap at length 8 and both sign-extension points can be reached. That covers the case where a full-width access still copies bit 31 upwards. A directed sweep covers every length, both flags and both values of the sign bit. Random words with random settings follow, and every result is compared without waiting for a clock edge.

// File: rtl/endian_norm_pkg.sv
package endian_norm_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lane_count(input int unsigned width);
    return width / BYTE_W;
  endfunction
endpackage

// File: rtl/lane_swapper.sv
module lane_swapper
  import endian_norm_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LEN_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned LANES = lane_count(DATA_W);

  logic [DATA_W-1:0] swapped;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 1; k <= LANES; k++) begin
        if ((k == int'(len_i)) && (g < k)) begin
          pick = data_i[(k-1-g)*BYTE_W +: BYTE_W];
        end
      end
    end
    assign swapped[g*BYTE_W +: BYTE_W] = pick;
  end

  assign data_o = en_i ? swapped : data_i;

  logic [DATA_W-1:0] low_mask;
  always_comb begin
    low_mask = '0;
    for (int b = 0; b < LANES; b++) begin
      if (b < int'(len_i)) low_mask[b*BYTE_W +: BYTE_W] = '1;
    end
    if (en_i && (int'(len_i) >= 1) && (int'(len_i) <= LANES)) begin
      // R3
      upper_zero_chk: assert ((data_o & ~low_mask) == '0)
        else $error("swapped bytes above access length not zero");
      // R2
      ones_kept_chk: assert ($countones(data_o) == $countones(data_i & low_mask))
        else $error("swap changed the set of bits within access length");
    end
  end
endmodule

// File: rtl/sign_stretcher.sv
module sign_stretcher #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned HALF_LEN = 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned HALF_UP = DATA_W - HALF_W;
  localparam int unsigned WORD_UP = DATA_W - WORD_W;

  logic              is_half;
  logic [DATA_W-1:0] half_ext;
  logic [DATA_W-1:0] word_ext;

  assign is_half  = (len_i == LEN_W'(HALF_LEN));
  assign half_ext = {{HALF_UP{data_i[HALF_W-1]}}, data_i[HALF_W-1:0]};
  assign word_ext = {{WORD_UP{data_i[WORD_W-1]}}, data_i[WORD_W-1:0]};

  always_comb begin
    if (!en_i)        data_o = data_i;
    else if (is_half) data_o = half_ext;
    else              data_o = word_ext;
  end

  always_comb begin
    if (en_i && is_half) begin
      // R5
      half_fill_chk: assert (($countones(data_o[DATA_W-1:HALF_W-1]) == 0) ||
                             ($countones(data_o[DATA_W-1:HALF_W-1]) == HALF_UP + 1))
        else $error("half-length sign fill broken");
    end
    if (en_i && !is_half) begin
      // R6
      word_fill_chk: assert ((($countones(data_o[DATA_W-1:WORD_W-1]) == 0) ||
                              ($countones(data_o[DATA_W-1:WORD_W-1]) == WORD_UP + 1)) &&
                             (data_o[WORD_W-1:0] == data_i[WORD_W-1:0]))
        else $error("word sign fill broken");
    end
  end
endmodule

// File: rtl/endian_normaliser.sv
module endian_normaliser #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned HALF_LEN = 2
) (
  input  logic [DATA_W-1:0] ld_raw_i,
  input  logic [DATA_W-1:0] st_opnd_i,
  input  logic              swap_en_i,
  input  logic              sext_en_i,
  input  logic [LEN_W-1:0]  acc_len_i,
  output logic [DATA_W-1:0] ld_norm_o,
  output logic [DATA_W-1:0] st_mem_o
);
  logic [DATA_W-1:0] ld_ordered;

  // load: reorder first, then widen (R7)
  lane_swapper #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ld_swap (
    .data_i (ld_raw_i),
    .en_i   (swap_en_i),
    .len_i  (acc_len_i),
    .data_o (ld_ordered)
  );

  sign_stretcher #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .HALF_W(HALF_W),
    .WORD_W(WORD_W), .HALF_LEN(HALF_LEN)
  ) u_ld_ext (
    .data_i (ld_ordered),
    .en_i   (sext_en_i),
    .len_i  (acc_len_i),
    .data_o (ld_norm_o)
  );

  // store: reorder before the data leaves (R8)
  lane_swapper #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_st_swap (
    .data_i (st_opnd_i),
    .en_i   (swap_en_i),
    .len_i  (acc_len_i),
    .data_o (st_mem_o)
  );

  always_comb begin
    if (!sext_en_i) begin
      // R1
      ld_plain_chk: assert (swap_en_i || (ld_norm_o == ld_raw_i))
        else $error("load path altered data with both flags low");
    end
  end
endmodule

// File: tb/endian_normaliser_tb_top.sv
module endian_normaliser_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] ld_raw, st_opnd;
  logic        swap_en, sext_en;
  logic [3:0]  acc_len;
  logic [63:0] ld_norm, st_mem;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  endian_normaliser dut_i (
    .ld_raw_i  (ld_raw),
    .st_opnd_i (st_opnd),
    .swap_en_i (swap_en),
    .sext_en_i (sext_en),
    .acc_len_i (acc_len),
    .ld_norm_o (ld_norm),
    .st_mem_o  (st_mem)
  );

  function automatic logic [63:0] m_swap(input logic [63:0] d, input int len);
    logic [63:0] r = '0;
    for (int i = 0; i < len; i++) r[i*8 +: 8] = d[(len-1-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] m_load(input logic [63:0] d, input bit sw,
                                         input bit sx, input int len);
    logic [63:0] v = sw ? m_swap(d, len) : d;
    if (sx) begin
      if (len == 2) v[63:16] = {48{v[15]}};
      else          v[63:32] = {32{v[31]}};
    end
    return v;
  endfunction

  function automatic logic [63:0] m_store(input logic [63:0] d, input bit sw, input int len);
    return sw ? m_swap(d, len) : d;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input bit sw, input bit sx, input int len);
    if (!sw) return sx ? (len == 2 ? "R5" : "R6") : "R1";
    if (sx)  return "R7";
    if (len == 1 || len == 8) return "R4";
    return "R2_R3";
  endfunction

  task automatic apply(input logic [63:0] l, input logic [63:0] s,
                       input bit sw, input bit sx, input int len);
    @(negedge clk);
    ld_raw = l; st_opnd = s; swap_en = sw; sext_en = sx; acc_len = 4'(len);
    #1;
    check({tag_of(sw, sx, len), " load"}, ld_norm, m_load(l, sw, sx, len));
    check({sw ? "R3_R8" : "R1", " store"}, st_mem, m_store(s, sw, len));
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lens[4] = '{1, 2, 4, 8};
    int seed_v;
    ld_raw = '0; st_opnd = '0; swap_en = 0; sext_en = 0; acc_len = 4'd8;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle load", ld_norm, 64'h0);
    check("R1 idle store", st_mem, 64'h0);

    // R4: full reversal and single-byte identity
    apply(64'h0102030405060708, 64'h1122334455667788, 1, 0, 8);
    check("R4 full", st_mem, 64'h8877665544332211);
    apply(64'hFFFFFFFFFFFFFF5A, 64'hAAAAAAAAAAAAAAC3, 1, 0, 1);
    check("R3 len1 store", st_mem, 64'h00000000000000C3);
    // R7: sign bit taken after swap
    apply(64'h0000000000000080, 64'h0, 1, 1, 2);
    check("R7 swapped sign", ld_norm, 64'hFFFFFFFFFFFF8000);
    // R6: length 8 still copies bit 31
    apply(64'h0123456789ABCDEF, 64'h0, 0, 1, 8);
    check("R6 len8", ld_norm, 64'hFFFFFFFF89ABCDEF);

    // sweep every length, flag pair and sign value
    foreach (lens[li]) begin
      for (int sw = 0; sw < 2; sw++)
        for (int sx = 0; sx < 2; sx++)
          for (int sb = 0; sb < 2; sb++) begin
            logic [63:0] pat = sb ? 64'h8081828384858687 : 64'h0706050403020100;
            apply(pat, ~pat, sw[0], sx[0], lens[li]);
          end
    end

    // R8: store unaffected by sign-extension flag
    apply(64'h0, 64'h00000000000080FF, 1, 1, 2);
    check("R8 store ignores sext", st_mem, 64'h000000000000FF80);

    // R9: change inputs with no clock edge between, outputs follow
    @(negedge clk);
    swap_en = 1; sext_en = 0; acc_len = 4'd4; st_opnd = 64'h00000000DEADBEEF;
    #1 check("R9 first", st_mem, 64'h00000000EFBEADDE);
    acc_len = 4'd2;
    #1 check("R9 follow", st_mem, 64'h000000000000EFBE);

    seed_v = $urandom(32'h5EED);
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] l = {$urandom, $urandom};
      logic [63:0] s = {$urandom, $urandom};
      int r = $urandom;
      apply(l, s, r[0], r[1], lens[r[3:2]]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule